// File: doc/BRIEF.md
# Infrared Return-to-Zero-Inverted Line Codec

This block sits between a UART's serial framing logic and an infrared optical front end. On the transmit side it takes the UART's NRZ bit stream and turns every zero bit into a short light pulse that lasts 3/16 of a bit time and starts at the beginning of the bit period. A one bit sends no pulse, and the optical line rests in the dark, no-pulse state. Both the bit period and its sixteenths are marked by single-cycle ticks from an external baud generator.

On the receive side the detector output is active low: a low level means light was seen. The line is first synchronised to the clock. A programmable digital glitch filter then accepts a low pulse only if it stays low for a set number of clock cycles. A qualified pulse pulls the NRZ receive output low for the rest of the current bit period, so that a standard UART receiver sees an ordinary zero bit. The link is half-duplex and works at data rates from 2.4 kb/s to 115.2 kb/s, which are set by the tick rates.

Top module: `irda_rzi_codec`

## Requirements
- R1: After reset `ir_tx` is low and `rx_nrz` is high.
- R2: When `tx_nrz` is 0 on a `bit_tick` cycle, `ir_tx` goes high in the next cycle. It stays high until PULSE_SUBS (default 3) `sub_tick` pulses after that `bit_tick` have been counted, which is 3/16 of a bit.
- R3: When `tx_nrz` is 1 on a `bit_tick` cycle, `ir_tx` stays low for the whole bit period.
- R4: `tx_nrz` is sampled only on `bit_tick` cycles. A change in the middle of a bit has no effect on `ir_tx`.
- R5: `ir_rx` is active low: a 0 means a pulse and idle is 1. It passes through SYNC_STAGES (default 2) flip-flops before the filter sees it.
- R6: With `filt_val` = F > 0, a pulse is qualified only after the synchronised line has been low for F consecutive clock cycles.
- R7: A single high cycle inside a low pulse reloads the filter count with F, so low segments on either side of the glitch do not add up.
- R8: With `filt_val` = 0 the filter is bypassed, and any low sample on the synchronised line qualifies at once.
- R9: A qualified pulse drives `rx_nrz` low from the next cycle. `rx_nrz` returns high on the next `bit_tick`.
- R10: A pulse that is not qualified, or no pulse at all, leaves `rx_nrz` high for the whole bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | Single-cycle pulse at the start of each bit period |
| sub_tick | input | 1 | Single-cycle pulse at each sixteenth of a bit |
| tx_nrz | input | 1 | NRZ transmit bit from the UART |
| ir_tx | output | 1 | Optical transmit drive, high while a light pulse is sent |
| ir_rx | input | 1 | Optical detector output, low while light is seen |
| filt_val | input | 8 | Minimum pulse width in clock cycles; 0 bypasses the filter |
| rx_nrz | output | 1 | Recovered NRZ receive bit to the UART |

## Verification
The hardest cases to reach are pulses that sit right at the filter limit: a low run of exactly F or F-1 cycles, and a run split by a single high glitch cycle whose halves only add up to F or more. The bench builds every receive bit from a start offset and two low segments separated by one high cycle. It sets the segment lengths to F-1 and F on purpose, and it also draws them at random together with F, including F = 0 and F = 1. Each transmit bit also toggles `tx_nrz` in the middle of the bit to show that it is ignored there.

// File: rtl/irda_rzi_codec.sv
module irda_rzi_codec #(
  parameter int SUB_PER_BIT = 16,
  parameter int PULSE_SUBS  = 3,
  parameter int FILT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              sub_tick,
  input  logic              tx_nrz,
  output logic              ir_tx,
  input  logic              ir_rx,
  input  logic [FILT_W-1:0] filt_val,
  output logic              rx_nrz
);
  localparam int SC_W = $clog2(SUB_PER_BIT + 1);
  localparam logic [SC_W-1:0] SC_MAX   = SC_W'(SUB_PER_BIT);
  localparam logic [SC_W-1:0] SC_PULSE = SC_W'(PULSE_SUBS);

  logic [SC_W-1:0] sub_cnt;
  logic            tx_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_cnt <= '0;
      tx_bit  <= 1'b1;
    end else if (bit_tick) begin
      sub_cnt <= '0;
      tx_bit  <= tx_nrz;
    end else if (sub_tick && sub_cnt != SC_MAX) begin
      sub_cnt <= sub_cnt + 1'b1;
    end
  end

  assign ir_tx = ~tx_bit & (sub_cnt < SC_PULSE);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  logic                   rx_prev;
  logic [FILT_W-1:0]      flt_cnt;
  logic                   qual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      rx_prev <= 1'b1;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], ir_rx};
      rx_prev <= rx_s;
    end
  end

  assign rx_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              flt_cnt <= '0;
    else if (rx_s)           flt_cnt <= filt_val;
    else if (flt_cnt != '0)  flt_cnt <= flt_cnt - 1'b1;
  end

  assign qual = ~rx_s & ((filt_val == '0) ? rx_prev : (flt_cnt == FILT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_nrz <= 1'b1;
    else if (qual)     rx_nrz <= 1'b0;
    else if (bit_tick) rx_nrz <= 1'b1;
  end
endmodule

module irda_rzi_codec_chk #(
  parameter int PULSE_SUBS = 3,
  parameter int FILT_W     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_tick,
  input logic              sub_tick,
  input logic              ir_tx,
  input logic              rx_s,
  input logic [FILT_W-1:0] filt_val,
  input logic              rx_nrz
);
  logic [7:0]        subs_seen;
  logic [FILT_W:0]   low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      subs_seen <= '0;
      low_run   <= '0;
    end else begin
      if (bit_tick) subs_seen <= '0;
      else if (sub_tick && subs_seen != 8'hff) subs_seen <= subs_seen + 1'b1;
      if (rx_s) low_run <= '0;
      else if (low_run != '1) low_run <= low_run + 1'b1;
    end
  end

  p_tx_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_tx) |-> $past(bit_tick));
  p_tx_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_tx |-> (subs_seen < 8'(PULSE_SUBS)));
  p_rx_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_nrz) |-> $past(bit_tick));
  p_rx_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_nrz) |-> $past(!rx_s));
  p_rx_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_nrz) |-> ($past(filt_val) == '0 ||
                       ($past(low_run) + 1'b1) >= {1'b0, $past(filt_val)}));
endmodule

bind irda_rzi_codec irda_rzi_codec_chk #(.PULSE_SUBS(PULSE_SUBS), .FILT_W(FILT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sub_tick(sub_tick),
  .ir_tx(ir_tx), .rx_s(rx_s), .filt_val(filt_val), .rx_nrz(rx_nrz)
);

// File: tb/test_irda_rzi_codec.sv
module test_irda_rzi_codec;
  localparam int CLK_P  = 10;
  localparam int SUBDIV = 4;
  localparam int BITLEN = 16 * SUBDIV;
  localparam int PULSE_CYC = 3 * SUBDIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, sub_tick = 1'b0, tx_nrz = 1'b1, ir_rx = 1'b1;
  logic [7:0] filt_val = 8'd0;
  logic ir_tx, rx_nrz;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  irda_rzi_codec i_irda_rzi_codec (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sub_tick(sub_tick),
    .tx_nrz(tx_nrz), .ir_tx(ir_tx), .ir_rx(ir_rx), .filt_val(filt_val),
    .rx_nrz(rx_nrz)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_qual(input int f, input int a, input int b);
    if (f == 0) return (a > 0) || (b > 0);
    return (a >= f) || (b >= f);
  endfunction

  function automatic bit rx_low_at(input int i, input int s, input int a, input int b);
    if (i >= s && i < s + a) return 1'b1;
    if (b > 0 && i >= s + a + 1 && i < s + a + 1 + b) return 1'b1;
    return 1'b0;
  endfunction

  task automatic do_bit(input bit txb, input bit tx_mid, input int f,
                        input int s, input int a, input int b, input string tag);
    int txcnt = 0;
    bit want = exp_qual(f, a, b);
    for (int i = 0; i < BITLEN; i++) begin
      @(negedge clk);
      if (i >= 1) txcnt += int'(ir_tx);
      if (i == 2) chk(rx_nrz == 1'b1, {"R9 release ", tag}, rx_nrz, 1);
      if (i == BITLEN - 1)
        chk(rx_nrz == !want, want ? {"R6/R8 R9 accept ", tag} : {"R7 R10 reject ", tag},
            rx_nrz, !want);
      bit_tick = (i == 0);
      sub_tick = (i % SUBDIV == 0);
      if (i == 0) begin
        tx_nrz = txb;
        filt_val = 8'(f);
      end else if (i == 30) tx_nrz = tx_mid;
      ir_rx = !rx_low_at(i, s, a, b);
    end
    chk(txcnt == (txb ? 0 : PULSE_CYC),
        txb ? {"R3 R4 no pulse ", tag} : {"R2 R4 pulse width ", tag},
        txcnt, txb ? 0 : PULSE_CYC);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(ir_tx == 1'b0, "R1 ir_tx reset", ir_tx, 0);
    chk(rx_nrz == 1'b1, "R1 rx_nrz reset", rx_nrz, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ir_tx == 1'b0 && rx_nrz == 1'b1, "R1 idle after reset", {ir_tx, rx_nrz}, 1);
    do_bit(1'b0, 1'b1, 0, 1, 1, 0, "R8 bypass one cycle");
    do_bit(1'b1, 1'b0, 0, 2, 0, 0, "R10 R5 idle line");
    do_bit(1'b0, 1'b0, 1, 1, 1, 0, "R6 F=1 one cycle");
    do_bit(1'b0, 1'b1, 10, 3, 9, 0, "R6 F=10 short");
    do_bit(1'b1, 1'b0, 10, 3, 10, 0, "R6 F=10 exact");
    do_bit(1'b0, 1'b0, 10, 2, 9, 9, "R7 split 9+9");
    do_bit(1'b1, 1'b1, 10, 2, 9, 10, "R7 split 9+10");
    do_bit(1'b0, 1'b1, 255, 1, 24, 24, "R6 F=255");
    for (int k = 0; k < 160; k++) begin
      int f = int'($urandom % 26);
      int s = 1 + int'($urandom % 4);
      int a = int'($urandom % 25);
      int b = ($urandom % 2) ? int'($urandom % 25) : 0;
      do_bit(bit'($urandom % 2), bit'($urandom % 2), f, s, a, b, "random");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule